// File: doc/BRIEF.md
# Hierarchical One-Hot to Binary Encoder

This combinational block turns a wide vector of one-bit select lines into the binary number of the line that is high. It is meant for wide control fabrics where thousands of guards take turns driving one shared memory port, such as a long run of store steps that each write one fixed address. One flat chain of conditional selects that long turns into a single huge expression. Here the lines are split into fixed-size chunks. Each chunk finds its own first asserted line with a short priority chain, and a second stage picks among the chunk results using a separate OR guard per chunk. The result is bit-identical to a flat first-match cascade, including when more than one line is high.

A companion path can also route a per-line data word onto the shared port and raise a write enable whenever any line is high. The line count, chunk size, word width and the presence of the data path are all parameters. The output width is derived from the line count.

Top module: `ohenc_top`

## Requirements
- R1: When exactly line i (counting from 0) is high, `idx` equals i, so line 0 gives 0 and line N-1 gives N-1.
- R2: `idx` is ceil(log2(N)) bits wide with a minimum of 1. With the default N of 4955 it is 13 bits wide.
- R3: When no line is high, `idx` is 0, `word` is 0 and `wr_en` is 0.
- R4: When several lines are high, `idx` is the lowest asserted position. This is the same value a flat ascending first-match cascade with a default of 0 would produce.
- R5: When N is not a multiple of the chunk size, the lines in the final, shorter chunk encode correctly. This includes line N-1, and the case where every line of that chunk is high.
- R6: `wr_en` is high exactly when at least one line is high.
- R7: When the data path is enabled, `word` equals bits [i*DW +: DW] of `data`, where i is the winning line from R4.
- R8: When the last line of one chunk and the first line of the next chunk are both high, the earlier chunk wins. A chunk whose guard is low never affects the result.
- R9: When the data path is disabled, `word` stays 0 while `idx` and `wr_en` still follow R1, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | N | Select lines, nominally one-hot; the lowest index has the highest priority |
| data | input | N*DW | Per-line data words; line i occupies bits [i*DW +: DW] |
| idx | output | OW = max(1, ceil(log2 N)) | Binary number of the winning line, or 0 when idle |
| word | output | DW | Data word of the winning line, or 0 |
| wr_en | output | 1 | High when any select line is high |

## Verification
Every single-hot position is driven. This tells apart an off-by-one or a wrong chunk base at each chunk boundary, and it catches a mapping error in the partial last chunk. The all-zero vector separates the idle default from the result for line 0, which shares the value 0 but must raise `wr_en`. Random multi-hot vectors at several densities, together with pairs made of the last line of one chunk and the first line of the next, distinguish a lowest-first order from a highest-first order at both the inner and the outer level. All of these patterns are repeated for several line counts and chunk sizes, including a single chunk, a chunk of one line, a chunk wider than N, and a build with the data path removed.

// File: rtl/ohenc_pkg.sv
package ohenc_pkg;

   // Output index width for n select lines: ceil(log2(n)), never below 1.
   function automatic int unsigned idx_width(int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Number of chunks needed to cover n lines in groups of size w.
   function automatic int unsigned chunk_count(int unsigned n, int unsigned w);
      return (n + w - 1) / w;
   endfunction

endpackage

// File: rtl/ohenc_chunk.sv
// One chunk: an OR guard plus a short first-match chain that reports a
// global index (BASE + local position) and the matching data word.
module ohenc_chunk #(
   parameter int unsigned W        = 64,
   parameter int unsigned BASE     = 0,
   parameter int unsigned OW       = 13,
   parameter int unsigned DW       = 8,
   parameter bit          HAS_DATA = 1'b1
) (
   input  logic [W-1:0]    sel,
   input  logic [W*DW-1:0] data,
   output logic            guard,
   output logic [OW-1:0]   idx,
   output logic [DW-1:0]   word
);

   // Guard is its own reduction, kept apart from the index chain.
   assign guard = |sel;

   // Walking downward leaves the lowest asserted line as the final writer.
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (sel[i]) idx = OW'(BASE + i);
      end
   end

   if (HAS_DATA) begin : g_word
      always_comb begin
         word = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (sel[i]) word = data[i*DW +: DW];
         end
      end
   end else begin : g_no_word
      assign word = '0;
   end

endmodule

// File: rtl/ohenc_merge.sv
// Outer stage: ascending first-match over chunk guards, default 0.
module ohenc_merge #(
   parameter int unsigned NC = 78,
   parameter int unsigned OW = 13,
   parameter int unsigned DW = 8
) (
   input  logic [NC-1:0]    guard,
   input  logic [NC*OW-1:0] idx_in,
   input  logic [NC*DW-1:0] word_in,
   output logic [OW-1:0]    idx,
   output logic [DW-1:0]    word
);

   always_comb begin
      idx  = '0;
      word = '0;
      for (int c = NC - 1; c >= 0; c--) begin
         if (guard[c]) begin
            idx  = idx_in[c*OW +: OW];
            word = word_in[c*DW +: DW];
         end
      end
   end

endmodule

// File: rtl/ohenc_top.sv
module ohenc_top #(
   parameter  int unsigned N        = 4955,
   parameter  int unsigned CHUNK    = 64,
   parameter  int unsigned DW       = 8,
   parameter  bit          HAS_DATA = 1'b1,
   localparam int unsigned OW       = ohenc_pkg::idx_width(N)
) (
   input  logic [N-1:0]    sel,
   input  logic [N*DW-1:0] data,
   output logic [OW-1:0]   idx,
   output logic [DW-1:0]   word,
   output logic            wr_en
);

   localparam int unsigned NC = ohenc_pkg::chunk_count(N, CHUNK);

   // Elaboration-time parameter checks.
   if (N < 1) begin : g_bad_n
      $error("ohenc_top: N must be at least 1");
   end
   if (CHUNK < 1) begin : g_bad_chunk
      $error("ohenc_top: CHUNK must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ohenc_top: DW must be at least 1");
   end

   logic [NC-1:0]    chunk_guard;
   logic [NC*OW-1:0] chunk_idx;
   logic [NC*DW-1:0] chunk_word;

   for (genvar c = 0; c < NC; c++) begin : g_chunk
      localparam int unsigned LO = c * CHUNK;
      localparam int unsigned CW = (LO + CHUNK > N) ? (N - LO) : CHUNK;

      ohenc_chunk #(
         .W        (CW),
         .BASE     (LO),
         .OW       (OW),
         .DW       (DW),
         .HAS_DATA (HAS_DATA)
      ) u_chunk (
         .sel   (sel[LO +: CW]),
         .data  (data[LO*DW +: CW*DW]),
         .guard (chunk_guard[c]),
         .idx   (chunk_idx[c*OW +: OW]),
         .word  (chunk_word[c*DW +: DW])
      );
   end

   ohenc_merge #(
      .NC (NC),
      .OW (OW),
      .DW (DW)
   ) u_merge (
      .guard   (chunk_guard),
      .idx_in  (chunk_idx),
      .word_in (chunk_word),
      .idx     (idx),
      .word    (word)
   );

   // Write enable reuses the per-chunk guards.
   assign wr_en = |chunk_guard;

endmodule

// File: rtl/ohenc_check.sv
// Port-level checks, evaluated whenever the select vector is fully known.
module ohenc_check #(
   parameter int unsigned N        = 4955,
   parameter int unsigned DW       = 8,
   parameter int unsigned OW       = 13,
   parameter bit          HAS_DATA = 1'b1
) (
   input logic [N-1:0]    sel,
   input logic [N*DW-1:0] data,
   input logic [OW-1:0]   idx,
   input logic [DW-1:0]   word,
   input logic            wr_en
);

   logic [N-1:0] below_mask;
   logic         any_hot;
   logic         idx_ok;

   assign any_hot    = |sel;
   assign idx_ok     = 32'(idx) < N;
   assign below_mask = ~({N{1'b1}} << idx);

   always_comb begin
      if (!$isunknown(sel)) begin
         a_r3_idle_zero: assert (any_hot || (idx == '0 && word == '0 && !wr_en))
            else $error("R3: idle outputs not zero");
         a_r6_wr_en: assert (wr_en == any_hot)
            else $error("R6: write enable disagrees with select lines");
         a_r1_idx_hits_line: assert (!any_hot || (idx_ok && sel[idx]))
            else $error("R1: index does not point at an asserted line");
         a_r4_lowest_wins: assert (!any_hot || (sel & below_mask) == '0)
            else $error("R4: a lower line is asserted than the reported one");
         if (HAS_DATA && any_hot && idx_ok) begin
            a_r7_word_match: assert (word == data[idx*DW +: DW])
               else $error("R7: word does not belong to the winning line");
         end
         if (!HAS_DATA) begin
            a_r9_no_data_zero: assert (word == '0)
               else $error("R9: word nonzero with data path disabled");
         end
      end
   end

endmodule

bind ohenc_top ohenc_check #(
   .N        (N),
   .DW       (DW),
   .OW       (OW),
   .HAS_DATA (HAS_DATA)
) u_ohenc_check (
   .sel   (sel),
   .data  (data),
   .idx   (idx),
   .word  (word),
   .wr_en (wr_en)
);

// File: tb/ohenc_tb_unit.sv
// One configuration under test, with directed scenarios and a flat reference.
module ohenc_tb_unit #(
   parameter int unsigned N        = 37,
   parameter int unsigned CHUNK    = 8,
   parameter int unsigned DW       = 8,
   parameter bit          HAS_DATA = 1'b1,
   parameter int unsigned NRAND    = 200
) (
   input  logic clk,
   output int   checks,
   output int   fails,
   output logic done
);

   localparam int unsigned EXP_W = (N <= 1) ? 1 : $clog2(N);
   localparam int unsigned NCH   = (N + CHUNK - 1) / CHUNK;

   logic [N-1:0]     sel;
   logic [N*DW-1:0]  data;
   logic [EXP_W-1:0] idx;
   logic [DW-1:0]    word;
   logic             wr_en;

   ohenc_top #(
      .N        (N),
      .CHUNK    (CHUNK),
      .DW       (DW),
      .HAS_DATA (HAS_DATA)
   ) dut_i (
      .sel   (sel),
      .data  (data),
      .idx   (idx),
      .word  (word),
      .wr_en (wr_en)
   );

   // Flat ascending first-match reference.
   function automatic int ref_first(logic [N-1:0] s);
      for (int i = 0; i < N; i++) begin
         if (s[i]) return i;
      end
      return 0;
   endfunction

   task automatic check_now(string req);
      int            f;
      logic          e_en;
      logic [DW-1:0] e_word;
      f      = ref_first(sel);
      e_en   = |sel;
      e_word = (HAS_DATA && e_en) ? data[f*DW +: DW] : '0;
      checks++;
      if (32'(idx) != f || wr_en != e_en || word != e_word) begin
         fails++;
         $display("FAIL %s N=%0d CHUNK=%0d: idx=%0d wr_en=%0b word=%0h expected idx=%0d wr_en=%0b word=%0h",
                  req, N, CHUNK, idx, wr_en, word, f, e_en, e_word);
      end
   endtask

   task automatic apply(logic [N-1:0] v, string req);
      @(negedge clk);
      sel = v;
      #1;
      check_now(req);
   endtask

   // R2 and R3: width and all-zero default.
   task automatic t_idle_and_width();
      checks++;
      if ($bits(idx) != EXP_W) begin
         fails++;
         $display("FAIL R2 N=%0d: width=%0d expected %0d", N, $bits(idx), EXP_W);
      end
      apply('0, "R3");
   endtask

   // R1, R6, R7 (R9 when data is off): every single-hot position.
   task automatic t_single_hot();
      for (int i = 0; i < N; i++) begin
         logic [N-1:0] v;
         v    = '0;
         v[i] = 1'b1;
         apply(v, HAS_DATA ? "R1,R6,R7" : "R1,R9");
      end
   endtask

   // R4: random multi-hot vectors at several densities.
   task automatic t_multi_hot();
      for (int k = 0; k < NRAND; k++) begin
         logic [N-1:0] v;
         int unsigned  dens;
         dens = (k % 3 == 0) ? 2 : ((k % 3 == 1) ? 9 : 97);
         for (int i = 0; i < N; i++) v[i] = ($urandom % dens) == 0;
         apply(v, "R4");
      end
   endtask

   // R8 and R5: chunk seams and the final chunk.
   task automatic t_boundaries();
      logic [N-1:0] v;
      int           lo;
      for (int c = 0; c + 1 < NCH; c++) begin
         v = '0;
         v[(c + 1) * CHUNK - 1] = 1'b1;
         v[(c + 1) * CHUNK]     = 1'b1;
         apply(v, "R8");
      end
      lo = (NCH - 1) * CHUNK;
      v  = '0;
      for (int i = lo; i < N; i++) v[i] = 1'b1;
      apply(v, "R5");
      v        = '0;
      v[N - 1] = 1'b1;
      apply(v, "R5");
      apply('1, "R4");
   endtask

   initial begin
      checks = 0;
      fails  = 0;
      done   = 1'b0;
      sel    = '0;
      for (int i = 0; i < N; i++) data[i*DW +: DW] = DW'(i * 29 + 3);
      t_idle_and_width();
      t_single_hot();
      t_multi_hot();
      t_boundaries();
      apply('0, "R3");
      done = 1'b1;
   end

endmodule

// File: tb/ohenc_top_tb_top.sv
module ohenc_top_tb_top;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int   c0, c1, c2, c3, c4;
   int   f0, f1, f2, f3, f4;
   logic d0, d1, d2, d3, d4;
   int   wd_fail;

   ohenc_tb_unit #(.N(4955), .CHUNK(64), .DW(8),  .HAS_DATA(1'b1), .NRAND(200))
      u_big   (.clk(clk), .checks(c0), .fails(f0), .done(d0));
   ohenc_tb_unit #(.N(37),   .CHUNK(8),  .DW(4),  .HAS_DATA(1'b1), .NRAND(300))
      u_part  (.clk(clk), .checks(c1), .fails(f1), .done(d1));
   ohenc_tb_unit #(.N(16),   .CHUNK(16), .DW(6),  .HAS_DATA(1'b1), .NRAND(200))
      u_one   (.clk(clk), .checks(c2), .fails(f2), .done(d2));
   ohenc_tb_unit #(.N(1),    .CHUNK(4),  .DW(3),  .HAS_DATA(1'b0), .NRAND(20))
      u_tiny  (.clk(clk), .checks(c3), .fails(f3), .done(d3));
   ohenc_tb_unit #(.N(100),  .CHUNK(1),  .DW(5),  .HAS_DATA(1'b0), .NRAND(200))
      u_unit  (.clk(clk), .checks(c4), .fails(f4), .done(d4));

   initial begin
      wd_fail = 0;
      fork
         wait (d0 && d1 && d2 && d3 && d4);
         repeat (150000) @(posedge clk);
      join_any
      if (!(d0 && d1 && d2 && d3 && d4)) begin
         wd_fail = 1;
         $display("FAIL watchdog: run did not complete, expected all scenarios done");
      end
      $display("End of test - %0d assertions evaluated, %0d failures",
               c0 + c1 + c2 + c3 + c4 + wd_fail,
               f0 + f1 + f2 + f3 + f4 + wd_fail);
      $finish;
   end

endmodule